// File: doc/BRIEF.md
# Asymmetric-Width Dual-Port RAM

This block is a simple dual-port memory whose write port is narrow and whose read port is wide. Its storage is an array of identical narrow dual-port banks. The write address carries extra low-order bits. A decoder turns those bits into a one-hot write enable, so each write lands in exactly one bank. The upper write-address bits name the shared row. A read returns every bank's word at one row address, joined into a single wide word.

The wide width must be a power-of-two multiple of the narrow width. When the two widths are equal there is a single bank. The decoder and the join then pass straight through, and the block acts as an ordinary symmetric RAM. The whole array can also be preloaded in one clock from a flat image input.

Top module: `asym_ram`

## Requirements
- R1: A read with `rdEn` high returns the wide word of row `rdAddr` on `rdData` after the next rising edge (one cycle of latency). Bank k supplies bits `[k*NARROW_W +: NARROW_W]`, so bank 0 is the least significant slice.
- R2: A write with `wrEn` high stores `wrData` into slice `wrAddr[SEL_BITS-1:0]` of row `wrAddr[WA_W-1:SEL_BITS]`. Every other slice of that row, and every other row, keeps its value.
- R3: During any accepted write, exactly one bank write enable is active.
- R4: When a read and a write address the same row in the same cycle, the read returns the row as it was before that write. The write still takes effect for later reads.
- R5: While `initLoad` is high at a rising edge, every row r is loaded from `initImage[r*WIDE_W +: WIDE_W]`, using the same slice order as R1.
- R6: A write requested in the same cycle as `initLoad` is ignored, and the preloaded image is kept.
- R7: While `rdEn` is low, `rdData` holds its previous value, even if the row it came from is written.
- R8: While `rstN` is low, `rdData` is cleared to zero. The memory contents are not reset.
- R9: With `NARROW_W` equal to `WIDE_W`, the block acts as a symmetric RAM. It has one bank, and the write and read addresses have the same width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low reset of the read data register |
| initLoad | input | 1 | Load the whole array from `initImage` |
| initImage | input | DEPTH*WIDE_W | Flat preload image, row 0 in the least significant bits |
| wrEn | input | 1 | Narrow write request |
| wrAddr | input | WA_W | Narrow write address: row bits above bank-select bits |
| wrData | input | NARROW_W | Narrow write data |
| rdEn | input | 1 | Wide read request |
| rdAddr | input | RA_W | Wide read row address |
| rdData | output | WIDE_W | Wide read data, registered |

## Verification
Two pairs of functions can fall in the same cycle.

The first pair is a write and a read of the same row. The bench drives both on one edge. It expects the pre-write row on `rdData`, then reads the row again and expects the new slice.

The second pair is a write and a whole-array preload. The bench raises `initLoad` together with a write to row 0 that carries a distinct byte. It judges the result by reading every row back and comparing each against the image alone.

// File: rtl/asym_pkg.sv
package asym_pkg;
  // Strobes from the write-side control to the storage datapath.
  typedef struct packed {
    logic loadAll;   // preload whole array this edge
    logic writeGo;   // accepted narrow write this edge
  } ctrl_strobes_t;
endpackage

// File: rtl/asym_bank.sv
module asym_bank #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   load,
  input  logic [DEPTH*WIDTH-1:0] loadImage,
  input  logic                   we,
  input  logic [AW-1:0]          wAddr,
  input  logic [WIDTH-1:0]       wData,
  input  logic                   re,
  input  logic [AW-1:0]          rAddr,
  output logic [WIDTH-1:0]       rData
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (load) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= loadImage[i*WIDTH +: WIDTH];
    end else if (we) begin
      mem[wAddr] <= wData;
    end
  end

  // Read register samples the array before this edge's write (old data).
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)   rData <= '0;
    else if (re) rData <= mem[rAddr];
  end
endmodule

// File: rtl/asym_ctrl.sv
module asym_ctrl
  import asym_pkg::*;
#(
  parameter int RATIO = 4,
  parameter int RA_W  = 4,
  localparam int SEL_BITS = $clog2(RATIO),
  localparam int WA_W = RA_W + SEL_BITS
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            wrEn,
  input  logic            initLoad,
  input  logic [WA_W-1:0] wrAddr,
  output ctrl_strobes_t   strobes,
  output logic [RATIO-1:0] bankWe,
  output logic [RA_W-1:0] rowAddr
);
  always_comb begin
    strobes.loadAll = initLoad;
    strobes.writeGo = wrEn && !initLoad;
  end

  generate
    if (RATIO == 1) begin : g_pass
      assign bankWe  = strobes.writeGo;
      assign rowAddr = wrAddr;
    end else begin : g_decode
      always_comb begin
        bankWe = '0;
        if (strobes.writeGo) bankWe = RATIO'(1) << wrAddr[SEL_BITS-1:0];
      end
      assign rowAddr = wrAddr[WA_W-1:SEL_BITS];
    end
  endgenerate

  // R3: a write request outside a preload enables exactly one bank
  a_r3_one_bank: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !initLoad) |-> ($countones(bankWe) == 1));

  // R6: a preload never lets a bank write through
  a_r6_load_blocks_write: assert property (@(posedge clk) disable iff (!rstN)
    initLoad |-> (bankWe == '0));
endmodule

// File: rtl/asym_datapath.sv
module asym_datapath
  import asym_pkg::*;
#(
  parameter int NARROW_W = 8,
  parameter int RATIO    = 4,
  parameter int DEPTH    = 16,
  localparam int RA_W   = $clog2(DEPTH),
  localparam int WIDE_W = NARROW_W * RATIO
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  ctrl_strobes_t           strobes,
  input  logic [RATIO-1:0]        bankWe,
  input  logic [RA_W-1:0]         rowAddr,
  input  logic [NARROW_W-1:0]     wrData,
  input  logic [DEPTH*WIDE_W-1:0] initImage,
  input  logic                    rdEn,
  input  logic [RA_W-1:0]         rdAddr,
  output logic [WIDE_W-1:0]       rdData
);
  logic [RATIO-1:0][DEPTH*NARROW_W-1:0] bankImg;
  logic [RATIO-1:0][NARROW_W-1:0]       bankQ;

  for (genvar b = 0; b < RATIO; b++) begin : g_bank
    for (genvar r = 0; r < DEPTH; r++) begin : g_img
      assign bankImg[b][r*NARROW_W +: NARROW_W] =
        initImage[r*WIDE_W + b*NARROW_W +: NARROW_W];
    end

    asym_bank #(.WIDTH(NARROW_W), .DEPTH(DEPTH)) u_bank (
      .clk      (clk),
      .rstN     (rstN),
      .load     (strobes.loadAll),
      .loadImage(bankImg[b]),
      .we       (bankWe[b]),
      .wAddr    (rowAddr),
      .wData    (wrData),
      .re       (rdEn),
      .rAddr    (rdAddr),
      .rData    (bankQ[b])
    );

    assign rdData[b*NARROW_W +: NARROW_W] = bankQ[b];
  end

  // R7: no read request, no change on the wide output
  a_r7_hold: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> $stable(rdData));
endmodule

// File: rtl/asym_ram.sv
module asym_ram
  import asym_pkg::*;
#(
  parameter int NARROW_W = 8,
  parameter int WIDE_W   = 32,
  parameter int DEPTH    = 16,
  localparam int RATIO    = WIDE_W / NARROW_W,
  localparam int SEL_BITS = $clog2(RATIO),
  localparam int RA_W     = $clog2(DEPTH),
  localparam int WA_W     = RA_W + SEL_BITS
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    initLoad,
  input  logic [DEPTH*WIDE_W-1:0] initImage,
  input  logic                    wrEn,
  input  logic [WA_W-1:0]         wrAddr,
  input  logic [NARROW_W-1:0]     wrData,
  input  logic                    rdEn,
  input  logic [RA_W-1:0]         rdAddr,
  output logic [WIDE_W-1:0]       rdData
);
  ctrl_strobes_t    strobes;
  logic [RATIO-1:0] bankWe;
  logic [RA_W-1:0]  rowAddr;

  initial begin
    assert (RATIO * NARROW_W == WIDE_W && (RATIO & (RATIO - 1)) == 0)
      else $error("R9: wide width must be a power-of-two multiple of narrow width");
  end

  asym_ctrl #(.RATIO(RATIO), .RA_W(RA_W)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (wrEn),
    .initLoad(initLoad),
    .wrAddr  (wrAddr),
    .strobes (strobes),
    .bankWe  (bankWe),
    .rowAddr (rowAddr)
  );

  asym_datapath #(.NARROW_W(NARROW_W), .RATIO(RATIO), .DEPTH(DEPTH)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .bankWe   (bankWe),
    .rowAddr  (rowAddr),
    .wrData   (wrData),
    .initImage(initImage),
    .rdEn     (rdEn),
    .rdAddr   (rdAddr),
    .rdData   (rdData)
  );

  // R8: reset leaves the read output at zero
  a_r8_reset_clear: assert property (@(posedge clk)
    !rstN |=> (rdData == '0));
endmodule

// File: tb/asym_ram_test.sv
module asym_ram_test;
  logic clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // main instance: 8-bit writes, 32-bit reads, 16 rows
  logic          rstN = 1'b0;
  logic          initLoad = 1'b0;
  logic [511:0]  initImage = '0;
  logic          wrEn = 1'b0;
  logic [5:0]    wrAddr = '0;
  logic [7:0]    wrData = '0;
  logic          rdEn = 1'b0;
  logic [3:0]    rdAddr = '0;
  logic [31:0]   rdData;
  logic [31:0]   model [16];

  asym_ram #(.NARROW_W(8), .WIDE_W(32), .DEPTH(16)) uut (
    .clk(clk), .rstN(rstN), .initLoad(initLoad), .initImage(initImage),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData));

  // symmetric instance: 16-bit both ports, 4 rows
  logic          sInit = 1'b0;
  logic [63:0]   sImage = '0;
  logic          sWrEn = 1'b0;
  logic [1:0]    sWrAddr = '0;
  logic [15:0]   sWrData = '0;
  logic          sRdEn = 1'b0;
  logic [1:0]    sRdAddr = '0;
  logic [15:0]   sRdData;

  asym_ram #(.NARROW_W(16), .WIDE_W(16), .DEPTH(4)) uutSym (
    .clk(clk), .rstN(rstN), .initLoad(sInit), .initImage(sImage),
    .wrEn(sWrEn), .wrAddr(sWrAddr), .wrData(sWrData),
    .rdEn(sRdEn), .rdAddr(sRdAddr), .rdData(sRdData));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] imgRow(input int r);
    return {8'(r + 8'h40), 8'(r + 8'h30), 8'(r + 8'h20), 8'(r + 8'h10)};
  endfunction

  task automatic doWrite(input logic [3:0] row, input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = {row, sel}; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
    model[row][sel*8 +: 8] = d;
  endtask

  task automatic doRead(input logic [3:0] row, input string tag);
    @(negedge clk);
    rdEn = 1'b1; rdAddr = row;
    @(negedge clk);
    rdEn = 1'b0;
    check(tag, rdData, model[row]);
  endtask

  task automatic testReset();
    repeat (3) @(negedge clk);
    check("R8 reset clears rdData", rdData, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    check("R8 rdData zero after reset", rdData, 32'h0);
  endtask

  task automatic testInitWithWrite();
    for (int r = 0; r < 16; r++) initImage[r*32 +: 32] = imgRow(r);
    @(negedge clk);
    initLoad = 1'b1; wrEn = 1'b1; wrAddr = 6'd0; wrData = 8'hEE;
    @(negedge clk);
    initLoad = 1'b0; wrEn = 1'b0;
    for (int r = 0; r < 16; r++) model[r] = imgRow(r);
    doRead(4'd0, "R6 write ignored during preload");
    for (int r = 1; r < 16; r++) doRead(4'(r), "R5 preload row");
  endtask

  task automatic testSliceWrite();
    doWrite(4'd5, 2'd2, 8'hA7);
    doRead(4'd5, "R2 single slice write");
    doRead(4'd4, "R2 neighbour row untouched");
    doWrite(4'd7, 2'd0, 8'h11);
    doWrite(4'd7, 2'd1, 8'h22);
    doWrite(4'd7, 2'd2, 8'h33);
    doWrite(4'd7, 2'd3, 8'h44);
    @(negedge clk);
    rdEn = 1'b1; rdAddr = 4'd7;
    @(negedge clk);
    rdEn = 1'b0;
    check("R1 bank0 in lsb slice", rdData, 32'h44332211);
    doWrite(4'd15, 2'd3, 8'h9C);
    doRead(4'd15, "R3 top slice of last row");
  endtask

  task automatic testSameRow();
    logic [31:0] old;
    old = model[9];
    @(negedge clk);
    wrEn = 1'b1; wrAddr = {4'd9, 2'd1}; wrData = 8'h77;
    rdEn = 1'b1; rdAddr = 4'd9;
    @(negedge clk);
    wrEn = 1'b0; rdEn = 1'b0;
    check("R4 same-row read returns old data", rdData, old);
    model[9][15:8] = 8'h77;
    doRead(4'd9, "R4 write lands after collision");
  endtask

  task automatic testHold();
    logic [31:0] held;
    doRead(4'd3, "R7 setup read");
    held = model[3];
    doWrite(4'd3, 2'd0, 8'h5A);
    @(negedge clk);
    check("R7 rdData held without rdEn", rdData, held);
    doRead(4'd3, "R7 later read sees write");
  endtask

  task automatic testSymmetric();
    for (int r = 0; r < 4; r++) sImage[r*16 +: 16] = 16'(16'hC0 + r);
    @(negedge clk);
    sInit = 1'b1;
    @(negedge clk);
    sInit = 1'b0; sWrEn = 1'b1; sWrAddr = 2'd2; sWrData = 16'hBEEF;
    @(negedge clk);
    sWrEn = 1'b0; sRdEn = 1'b1; sRdAddr = 2'd2;
    @(negedge clk);
    sRdEn = 1'b0;
    check("R9 symmetric full-width write", {16'h0, sRdData}, 32'h0000BEEF);
    sRdEn = 1'b1; sRdAddr = 2'd1;
    @(negedge clk);
    sRdEn = 1'b0;
    check("R9 symmetric preload row", {16'h0, sRdData}, 32'h000000C1);
  endtask

  initial begin
    testReset();
    testInitWithWrite();
    testSliceWrite();
    testSameRow();
    testHold();
    testSymmetric();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule